// File: doc/BRIEF.md
# Flash Bus Write Qualifier

This block sits between the asynchronous strobe pins of a flash-style parallel bus (active-low chip enable, write enable and output enable), the address and data buses, and the internal command decoder. It samples the strobes with the system clock, passes each one through a two-stage synchronizer and a settling filter, and discards pulses too short to be genuine. It then decides which write cycles are legitimate and hands each accepted cycle to the decoder as a single-clock event that carries the captured address and data.

Three inhibit conditions are enforced. The first is the logical one: a write needs chip enable and write enable low and output enable high. The second is supply lockout: a digital low-supply input stands in for the analogue comparator, blocks all writes and drives a reset to the command logic. The third is power-up inhibit: a cycle already in progress when lockout ends is never accepted. The address is taken when the later of the two enabling strobes falls. The data is taken when the earlier of them rises. The address and data buses are assumed stable from the raw strobe edge until the filtered edge, which is FILT_N + 2 clocks later.

Top module: `fbus_write_qual`

## Requirements
- R1: After reset wr_valid is 0, wr_addr and wr_data are 0, and cmd_reset is 1: lockout is treated as active until supply_low has been sampled low.
- R2: A qualified write cycle produces exactly one wr_valid pulse lasting one clock, together with its address and data.
- R3: Each strobe level is synchronized by two flops, and its filtered copy changes only after FILT_N consecutive clocks at the new level. A strobe pulse shorter than FILT_N clocks starts no write cycle.
- R4: No write cycle starts while output enable is low, chip enable is high or write enable is high.
- R5: wr_addr holds the address that was present when the later of chip enable and write enable went low.
- R6: wr_data holds the data that was present when the earlier of chip enable and write enable went high.
- R7: While the filtered supply_low is 1, cmd_reset is 1 and no wr_valid is issued. supply_low has a synchronizer and a one-clock filter.
- R8: If chip enable and write enable are both low when lockout ends, the cycle in progress is not accepted. Writes resume only after chip enable or write enable has been seen high.
- R9: A cycle that ends because output enable goes low, or because lockout asserts, produces no wr_valid.
- R10: Back-to-back cycles, with chip enable held low and write enable toggled, each produce their own pulse with their own data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n_pin | input | 1 | Raw chip enable, active low |
| we_n_pin | input | 1 | Raw write enable, active low |
| oe_n_pin | input | 1 | Raw output enable, active low |
| addr_pin | input | ADDR_W | Address bus |
| data_pin | input | DATA_W | Data bus |
| supply_low | input | 1 | Digital low-supply lockout indication |
| wr_valid | output | 1 | One-clock pulse marking a qualified write |
| wr_addr | output | ADDR_W | Captured address of the last write |
| wr_data | output | DATA_W | Captured data of the last write |
| cmd_reset | output | 1 | Reset to the command logic during lockout |

## Verification
Some properties are checked by assertions on every cycle. A filtered strobe only ever moves to the synchronized level. wr_valid never lasts two clocks, never follows a clock with lockout, output enable low or no open cycle, and a cycle never opens while the power-up inhibit is set. Other behaviour needs the bench scenarios and its clock-by-clock reference model: the exact filter latency and glitch rejection, which of the overlapping strobe edges sets the captured address and data, and the power-up case where the first rising write enable is dropped.

// File: rtl/fbwq_pkg.sv
// Shared definitions for the flash bus write qualifier.
// Assumes the strobes are active low and idle high.
package fbwq_pkg;
    localparam int STROBE_CNT = 3;
    localparam int IDX_CE     = 0;
    localparam int IDX_WE     = 1;
    localparam int IDX_OE     = 2;
    localparam logic [STROBE_CNT-1:0] STROBES_IDLE = '1;
endpackage

// File: rtl/fbwq_level_filter.sv
// Synchronizes one asynchronous level and lets its filtered copy follow
// only after STEPS consecutive clocks at the new level.
// Assumes the raw input idles at RESET_VAL.
module fbwq_level_filter #(
    parameter int   STEPS     = 4,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic level_out
);
    localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    logic          sync1_q, sync2_q, filt_q;
    logic [CW-1:0] run_q;

    // two-flop synchronizer followed by a saturating settle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= RESET_VAL;
            sync2_q <= RESET_VAL;
            filt_q  <= RESET_VAL;
            run_q   <= '0;
        end else begin
            sync1_q <= raw_in;
            sync2_q <= sync1_q;
            if (sync2_q == filt_q) begin
                run_q <= '0;
            end else if (run_q == LAST) begin
                filt_q <= sync2_q;
                run_q  <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign level_out = filt_q;

    // R3: a filtered change always moves to the synchronized level
    assert_strobe_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_q != $past(filt_q)) |-> (filt_q == $past(sync2_q)));

    // R3: filtered level holds while synchronized level agrees with it
    assert_strobe_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sync2_q == filt_q) |=> $stable(filt_q));
endmodule

// File: rtl/fbwq_cycle_qualifier.sv
// Applies the logical, lockout and power-up inhibits to filtered strobes,
// captures the address at the opening of a cycle and the data at its close,
// and emits a one-clock event for each accepted cycle.
// Assumes address and data are stable across the filter delay.
module fbwq_cycle_qualifier #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_f,
    input  logic              we_f,
    input  logic              oe_f,
    input  logic              lock_f,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    logic              inhibit_q, in_cycle_q, valid_q;
    logic [ADDR_W-1:0] addr_cap_q, addr_out_q;
    logic [DATA_W-1:0] data_out_q;
    logic              open_now, strobe_end, accept_end;

    // a write window is open only with both enables low, output enable high
    assign open_now   = !ce_f && !we_f && oe_f && !lock_f && !inhibit_q;
    // the first enable to rise closes the window
    assign strobe_end = ce_f || we_f;
    assign accept_end = in_cycle_q && !open_now && strobe_end && oe_f && !lock_f;

    // power-up inhibit: set during lockout, cleared once an enable is high
    always_ff @(posedge clk) begin
        if (!rst_n)      inhibit_q <= 1'b1;
        else if (lock_f) inhibit_q <= 1'b1;
        else if (strobe_end) inhibit_q <= 1'b0;
    end

    // cycle tracking and address capture at the later falling enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_cycle_q <= 1'b0;
            addr_cap_q <= '0;
        end else begin
            in_cycle_q <= open_now;
            if (open_now && !in_cycle_q) addr_cap_q <= addr_in;
        end
    end

    // event output with data taken at the earlier rising enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q    <= 1'b0;
            addr_out_q <= '0;
            data_out_q <= '0;
        end else begin
            valid_q <= accept_end;
            if (accept_end) begin
                addr_out_q <= addr_cap_q;
                data_out_q <= data_in;
            end
        end
    end

    assign wr_valid = valid_q;
    assign wr_addr  = addr_out_q;
    assign wr_data  = data_out_q;

    // R2: the event lasts a single clock
    assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);
    // R6: an event closes a cycle that was open
    assert_event_after_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> $past(in_cycle_q));
    // R7: no event is issued after a clock in lockout
    assert_lock_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lock_f |=> !valid_q);
    // R8: a cycle never opens while power-up inhibit is set
    assert_start_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_cycle_q) |-> !$past(inhibit_q));
    // R9: an event needs output enable high at the closing clock
    assert_oe_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> $past(oe_f));
endmodule

// File: rtl/fbus_write_qual.sv
// Top of the write qualifier: filters the three strobes and the lockout
// input, then qualifies write cycles for the command decoder.
// Assumes one clock domain; the pins are asynchronous to it.
module fbus_write_qual #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int FILT_N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n_pin,
    input  logic              we_n_pin,
    input  logic              oe_n_pin,
    input  logic [ADDR_W-1:0] addr_pin,
    input  logic [DATA_W-1:0] data_pin,
    input  logic              supply_low,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              cmd_reset
);
    import fbwq_pkg::*;

    logic [STROBE_CNT-1:0] raw_strobes, filt_strobes;
    logic                  lock_f;

    assign raw_strobes[IDX_CE] = ce_n_pin;
    assign raw_strobes[IDX_WE] = we_n_pin;
    assign raw_strobes[IDX_OE] = oe_n_pin;

    // one settle filter per strobe
    for (genvar i = 0; i < STROBE_CNT; i++) begin : g_strobe
        fbwq_level_filter #(.STEPS(FILT_N), .RESET_VAL(STROBES_IDLE[i])) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_in   (raw_strobes[i]),
            .level_out(filt_strobes[i])
        );
    end

    // lockout is synchronized only; it resets asserted
    fbwq_level_filter #(.STEPS(1), .RESET_VAL(1'b1)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (supply_low),
        .level_out(lock_f)
    );

    fbwq_cycle_qualifier #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_f    (filt_strobes[IDX_CE]),
        .we_f    (filt_strobes[IDX_WE]),
        .oe_f    (filt_strobes[IDX_OE]),
        .lock_f  (lock_f),
        .addr_in (addr_pin),
        .data_in (data_pin),
        .wr_valid(wr_valid),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    assign cmd_reset = lock_f;
endmodule

// File: tb/fbus_write_qual_tb.sv
module fbus_write_qual_tb;
    localparam int AW = 16;
    localparam int DW = 8;
    localparam int FN = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b0, we_n = 1'b0, oe_n = 1'b1, sup_low = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data = '0;
    logic wr_valid, cmd_reset;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int checks = 0, failures = 0, pulses = 0;
    string cur_req = "R1";
    logic [AW-1:0] last_a;
    logic [DW-1:0] last_d;

    always #5 clk = ~clk;

    fbus_write_qual #(.ADDR_W(AW), .DATA_W(DW), .FILT_N(FN)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n_pin(ce_n), .we_n_pin(we_n),
        .oe_n_pin(oe_n), .addr_pin(addr), .data_pin(data),
        .supply_low(sup_low), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .cmd_reset(cmd_reset)
    );

    // behavioural reference: raw sample history, settle rule, cycle rules
    logic [3:0] rawq[$];
    logic [3:0] hist[$];
    logic [3:0] mf;
    logic m_inh, m_inc, m_ev, m_act;
    logic [AW-1:0] m_acap, m_a;
    logic [DW-1:0] m_d;

    always @(posedge clk) begin
        if (!rst_n) begin
            rawq = '{4'hF, 4'hF};
            hist.delete();
            mf = 4'hF; m_inh = 1'b1; m_inc = 1'b0; m_ev = 1'b0;
            m_acap = '0; m_a = '0; m_d = '0;
        end else begin
            m_act = !mf[0] && !mf[1] && mf[2] && !mf[3] && !m_inh;
            m_ev = m_inc && !m_act && (mf[0] || mf[1]) && mf[2] && !mf[3];
            if (m_ev) begin m_a = m_acap; m_d = data; end
            if (m_act && !m_inc) m_acap = addr;
            if (mf[3]) m_inh = 1'b1;
            else if (mf[0] || mf[1]) m_inh = 1'b0;
            m_inc = m_act;
            hist.push_back(rawq[0]);
            if (hist.size() > 8) void'(hist.pop_front());
            for (int p = 0; p < 4; p++) begin
                int need;
                logic same;
                need = (p == 3) ? 1 : FN;
                if (hist.size() >= need) begin
                    same = 1'b1;
                    for (int k = 1; k <= need; k++)
                        if (hist[hist.size()-k][p] != hist[hist.size()-1][p]) same = 1'b0;
                    if (same) mf[p] = hist[hist.size()-1][p];
                end
            end
            void'(rawq.pop_front());
            rawq.push_back({sup_low, oe_n, we_n, ce_n});
        end
    end

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // clock-by-clock comparison against the reference, away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(cur_req, "wr_valid", wr_valid, m_ev);
            check(cur_req, "wr_addr", wr_addr, m_a);
            check(cur_req, "wr_data", wr_data, m_d);
            check(cur_req, "cmd_reset", cmd_reset, mf[3]);
            if (wr_valid) begin pulses++; last_a = wr_addr; last_d = wr_data; end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wcycle(logic [AW-1:0] a, logic [DW-1:0] d);
        addr = a; data = d; ce_n = 1'b0; tick(2);
        we_n = 1'b0; tick(12);
        we_n = 1'b1; tick(12);
        ce_n = 1'b1; tick(10);
    endtask

    initial begin
        int base;
        tick(3);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        // R1: reset state (lockout assumed active)
        check("R1", "reset wr_valid", wr_valid, 0);
        check("R1", "reset wr_addr", wr_addr, 0);
        check("R1", "reset cmd_reset", cmd_reset, 1);

        // R8: enables low and output enable high as lockout ends
        cur_req = "R8"; base = pulses;
        tick(8); sup_low = 1'b0; tick(10);
        check("R8", "cmd_reset released", cmd_reset, 0);
        we_n = 1'b1; tick(12); ce_n = 1'b1; tick(10);
        check("R8", "first cycle dropped", pulses - base, 0);
        wcycle(16'h0101, 8'h11);
        check("R8", "writes resume", pulses - base, 1);

        // R2: plain write
        cur_req = "R2"; base = pulses;
        wcycle(16'hBEEF, 8'h5A);
        check("R2", "pulse count", pulses - base, 1);
        check("R2", "addr", last_a, 16'hBEEF);
        check("R2", "data", last_d, 8'h5A);

        // R3: short write enable glitch
        cur_req = "R3"; base = pulses;
        ce_n = 1'b0; tick(10); we_n = 1'b0; tick(FN - 2); we_n = 1'b1; tick(14);
        ce_n = 1'b1; tick(10);
        check("R3", "glitch ignored", pulses - base, 0);

        // R4: output enable low blocks the cycle
        cur_req = "R4"; base = pulses;
        oe_n = 1'b0; tick(4);
        wcycle(16'h2222, 8'h22);
        oe_n = 1'b1; tick(10);
        check("R4", "oe low blocks", pulses - base, 0);

        // R5 and R6: write enable falls first, chip enable rises first
        cur_req = "R5"; base = pulses;
        addr = 16'h1111; data = 8'h3C; we_n = 1'b0; tick(10);
        addr = 16'hA5A5; ce_n = 1'b0; tick(14);
        cur_req = "R6";
        ce_n = 1'b1; tick(10);
        data = 8'hFF; addr = 16'h7777; tick(2);
        we_n = 1'b1; tick(12);
        check("R5", "addr at later fall", last_a, 16'hA5A5);
        check("R6", "data at earlier rise", last_d, 8'h3C);
        check("R6", "one pulse", pulses - base, 1);

        // R9: output enable drops mid-cycle
        cur_req = "R9"; base = pulses;
        ce_n = 1'b0; we_n = 1'b0; addr = 16'h3333; tick(12);
        oe_n = 1'b0; tick(10); we_n = 1'b1; ce_n = 1'b1; tick(10);
        oe_n = 1'b1; tick(10);
        check("R9", "oe abort", pulses - base, 0);

        // R7: lockout during a cycle
        cur_req = "R7"; base = pulses;
        ce_n = 1'b0; we_n = 1'b0; tick(12);
        sup_low = 1'b1; tick(6);
        check("R7", "cmd_reset asserted", cmd_reset, 1);
        we_n = 1'b1; ce_n = 1'b1; tick(10);
        sup_low = 1'b0; tick(8);
        check("R7", "lockout abort", pulses - base, 0);

        // R10: back-to-back with chip enable held low
        cur_req = "R10"; base = pulses;
        ce_n = 1'b0; addr = 16'h4444; data = 8'h44; tick(2);
        we_n = 1'b0; tick(12); we_n = 1'b1; tick(12);
        check("R10", "first data", last_d, 8'h44);
        addr = 16'h5555; data = 8'h55;
        we_n = 1'b0; tick(12); we_n = 1'b1; tick(12);
        ce_n = 1'b1; tick(10);
        check("R10", "pulse count", pulses - base, 2);
        check("R10", "second data", last_d, 8'h55);
        check("R10", "second addr", last_a, 16'h5555);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule